// File: doc/BRIEF.md
# Toggle Bit Polling Controller

This block runs on the host side of a flash interface and decides when an embedded program or erase operation has finished. Once started, it reads the device status byte in pairs through a request/acknowledge read port. It compares the toggle bit of the two reads in a pair. A stable bit means the operation is complete. A moving bit with the timeout bit clear means the device is still working, so another pair is read.

When the toggle bit moves and the timeout bit is set, the block does not fail at once. The toggle may have stopped at the same moment the timeout bit rose, so one more pair is read to confirm. If that pair is stable, the result is success. If the bit still moves, the block raises a one-cycle strobe for a reset command write and then reports failure. A parameter can cap the number of busy pairs; reaching the cap takes the same failure path. A yield request drops any pending read. When the yield ends, polling starts again from a fresh first read: no stored value and no confirm state carries over.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: While idle, a high `start_i` makes `busy_o` high on the next cycle, and a read request follows. `start_i` is ignored while busy.
- R2: Bit 6 of the status byte is the toggle bit. If bit 6 is equal in both reads of a pair (no confirm pending), `done_o` pulses one cycle after the second read's acknowledge, and no reset command is issued.
- R3: Only bit 6, and bit 5 when bit 6 differs, affect the outcome. A pair whose reads differ only in other bits (for example 0x44 then 0x64) completes as done.
- R4: If bit 6 differs within a pair and bit 5 of the second read is 0, the block reads another pair.
- R5: If bit 6 differs and bit 5 of the second read is 1, the block reads a confirm pair. If bit 6 is equal in that confirm pair, the result is done.
- R6: If bit 6 differs in the confirm pair, whatever the state of bit 5, `rst_cmd_o` pulses for one cycle after the second read's acknowledge. `fail_o` pulses on the following cycle.
- R7: While `yield_i` is high, `rd_req_o` is low from the next cycle on, and acknowledges are ignored. After the yield ends, polling restarts with a first read and the confirm state is cleared.
- R8: With MAX_PAIRS > 0, the MAX_PAIRS-th consecutive busy pair (bit 6 differs, bit 5 is 0) since start takes the R6 reset-then-fail path instead of another pair.
- R9: `done_o`, `fail_o` and `rst_cmd_o` are single-cycle pulses, at most one per cycle. `busy_o` is low in the cycle that `done_o` or `fail_o` is high.
- R10: `rd_req_o` stays high until `rd_ack_i` is seen (unless a yield arrives). It drops on the cycle after the acknowledge.
- R11: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin polling an operation |
| yield_i | input | 1 | Abandon polling for now; restart on release |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Read acknowledge, with data valid |
| rd_data_i | input | DATA_W | Status byte returned with the acknowledge |
| rst_cmd_o | output | 1 | One-cycle request to write the reset command |
| done_o | output | 1 | Operation completed successfully (pulse) |
| fail_o | output | 1 | Operation failed (pulse) |
| busy_o | output | 1 | Polling in progress |

## Verification
`busy_o` is due one cycle after `start_i` is sampled, and `done_o` or `rst_cmd_o` one cycle after the acknowledge of the second read in a pair. `fail_o` is due one cycle after `rst_cmd_o`. The bench samples every output on the falling edge, so each expected value is read half a cycle after the rising edge that produced it. A scoreboard monitor pairs each result pulse with the expected outcome queued by the driver. For each result it compares the kind of result, the number of status reads consumed, and whether `rst_cmd_o` was high exactly one cycle before.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_PAUSE,
    ST_RSTCMD
  } tpoll_state_e;

  typedef enum logic [1:0] {
    V_DONE,
    V_AGAIN,
    V_CONFIRM,
    V_FAIL
  } tpoll_verdict_e;

endpackage

// File: rtl/tpoll_req_port.sv
module tpoll_req_port (
  input  logic clk,
  input  logic rst,
  input  logic want_i,
  input  logic rd_ack_i,
  output logic rd_req_o,
  output logic got_o
);

  logic req_q;

  assign rd_req_o = req_q;
  assign got_o    = req_q & rd_ack_i & want_i;

  always_ff @(posedge clk) begin
    if (rst || !want_i) begin
      req_q <= 1'b0;
    end else if (req_q && rd_ack_i) begin
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b1;
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (req_q && !rd_ack_i && want_i) |=> req_q);

  p_req_gap_r10: assert property (@(posedge clk) disable iff (rst)
    (req_q && rd_ack_i) |=> !req_q);

endmodule

// File: rtl/tpoll_judge.sv
module tpoll_judge
  import tpoll_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TOGGLE_BIT  = 6,
  parameter int TIMEOUT_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              confirm_i,
  input  logic              limit_hit_i,
  output tpoll_verdict_e    verdict_o
);

  localparam logic [DATA_W-1:0] TOG_MASK = DATA_W'(1) << TOGGLE_BIT;
  localparam logic [DATA_W-1:0] TMO_MASK = DATA_W'(1) << TIMEOUT_BIT;

  logic [DATA_W-1:0] first_q;
  logic              toggled;
  logic              timed_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
    end else if (capture_i) begin
      first_q <= data_i;
    end
  end

  assign toggled   = |((data_i ^ first_q) & TOG_MASK);
  assign timed_out = |(data_i & TMO_MASK);

  always_comb begin
    if (!toggled) begin
      verdict_o = V_DONE;
    end else if (confirm_i) begin
      verdict_o = V_FAIL;
    end else if (timed_out) begin
      verdict_o = V_CONFIRM;
    end else if (limit_hit_i) begin
      verdict_o = V_FAIL;
    end else begin
      verdict_o = V_AGAIN;
    end
  end

endmodule

// File: rtl/tpoll_pair_limit.sv
module tpoll_pair_limit #(
  parameter int MAX_PAIRS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic bump_i,
  output logic hit_o
);

  localparam int CNT_W = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1;

  generate
    if (MAX_PAIRS > 0) begin : g_limit
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || clear_i) begin
          cnt_q <= '0;
        end else if (bump_i && !hit_o) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign hit_o = (cnt_q == CNT_W'(MAX_PAIRS - 1));
    end else begin : g_unlimited
      logic unused_in;
      assign unused_in = clk ^ rst ^ clear_i ^ bump_i;
      assign hit_o     = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import tpoll_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TOGGLE_BIT  = 6,
  parameter int TIMEOUT_BIT = 5,
  parameter int MAX_PAIRS   = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              yield_i,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rst_cmd_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              busy_o
);

  tpoll_state_e   state_q;
  logic           confirm_q;
  logic           want;
  logic           got;
  logic           limit_hit;
  tpoll_verdict_e verdict;

  assign want = ((state_q == ST_FIRST) || (state_q == ST_SECOND)) && !yield_i;

  tpoll_req_port u_req (
    .clk      (clk),
    .rst      (rst),
    .want_i   (want),
    .rd_ack_i (rd_ack_i),
    .rd_req_o (rd_req_o),
    .got_o    (got)
  );

  tpoll_judge #(
    .DATA_W      (DATA_W),
    .TOGGLE_BIT  (TOGGLE_BIT),
    .TIMEOUT_BIT (TIMEOUT_BIT)
  ) u_judge (
    .clk         (clk),
    .rst         (rst),
    .capture_i   (got && (state_q == ST_FIRST)),
    .data_i      (rd_data_i),
    .confirm_i   (confirm_q),
    .limit_hit_i (limit_hit),
    .verdict_o   (verdict)
  );

  tpoll_pair_limit #(
    .MAX_PAIRS (MAX_PAIRS)
  ) u_limit (
    .clk     (clk),
    .rst     (rst),
    .clear_i (state_q == ST_IDLE),
    .bump_i  (got && (state_q == ST_SECOND) && (verdict == V_AGAIN)),
    .hit_o   (limit_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      confirm_q <= 1'b0;
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
      rst_cmd_o <= 1'b0;
      busy_o    <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
      rst_cmd_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          confirm_q <= 1'b0;
          if (start_i) begin
            state_q <= ST_FIRST;
            busy_o  <= 1'b1;
          end
        end
        ST_FIRST: begin
          if (yield_i) begin
            state_q <= ST_PAUSE;
          end else if (got) begin
            state_q <= ST_SECOND;
          end
        end
        ST_SECOND: begin
          if (yield_i) begin
            state_q <= ST_PAUSE;
          end else if (got) begin
            case (verdict)
              V_DONE: begin
                state_q <= ST_IDLE;
                done_o  <= 1'b1;
                busy_o  <= 1'b0;
              end
              V_CONFIRM: begin
                state_q   <= ST_FIRST;
                confirm_q <= 1'b1;
              end
              V_FAIL: begin
                state_q   <= ST_RSTCMD;
                rst_cmd_o <= 1'b1;
              end
              default: state_q <= ST_FIRST;
            endcase
          end
        end
        ST_PAUSE: begin
          confirm_q <= 1'b0;
          if (!yield_i) begin
            state_q <= ST_FIRST;
          end
        end
        ST_RSTCMD: begin
          state_q <= ST_IDLE;
          fail_o  <= 1'b1;
          busy_o  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && (state_q == ST_IDLE)) |=> busy_o);

  p_done_clean_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(got) && !rst_cmd_o && !$past(rst_cmd_o)));

  p_cmd_then_fail_r6: assert property (@(posedge clk) disable iff (rst)
    rst_cmd_o |=> (fail_o && !rst_cmd_o));

  p_fail_after_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> $past(rst_cmd_o));

  p_yield_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    yield_i |=> !rd_req_o);

  p_pulses_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, fail_o, rst_cmd_o}));

  p_pulse_len_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o || fail_o) |=> (!done_o && !fail_o && !busy_o));

  p_busy_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o || fail_o) |-> !busy_o);

endmodule

// File: tb/toggle_poll_ctrl_tb_top.sv
`timescale 1ns/1ps
module toggle_poll_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       yield_i = 1'b0;
  logic       rd_ack_i = 1'b0;
  logic [7:0] rd_data_i = 8'h00;
  logic       rd_req_o, rst_cmd_o, done_o, fail_o, busy_o;

  always #2 clk = ~clk;

  toggle_poll_ctrl #(.MAX_PAIRS(4)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .yield_i(yield_i),
    .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .rst_cmd_o(rst_cmd_o), .done_o(done_o), .fail_o(fail_o), .busy_o(busy_o)
  );

  typedef struct {
    bit    is_fail;
    int    reads;
    string tag;
  } exp_t;

  exp_t     exp_q[$];
  bit [7:0] byte_q[$];
  int tests = 0, fails = 0;
  int acks_given = 0, stop_after = 1000000, results = 0;
  bit rst_prev = 0, rst_seen = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // read responder: one acknowledge per request, data from byte_q
  always @(negedge clk) begin
    if (rst) begin
      rd_ack_i = 1'b0;
    end else if (rd_req_o && !rd_ack_i && acks_given < stop_after) begin
      rd_ack_i = 1'b1;
      rd_data_i = (byte_q.size() > 0) ? byte_q.pop_front() : 8'h00;
      acks_given++;
    end else begin
      rd_ack_i = 1'b0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o || fail_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9", "unexpected result pulse", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(fail_o == e.is_fail, e.tag, "result kind (1=fail)", fail_o, e.is_fail);
          chk(acks_given == e.reads, e.tag, "status reads used", acks_given, e.reads);
          if (e.is_fail)
            chk(rst_prev, "R6", "rst_cmd_o one cycle before fail_o", rst_prev, 1);
          else
            chk(!rst_seen, "R2", "no reset command on done", rst_seen, 0);
          chk(!busy_o, "R9", "busy_o low at result", busy_o, 0);
        end
        results++;
      end
      rst_prev = rst_cmd_o;
      if (rst_cmd_o) rst_seen = 1;
    end
  end

  task automatic begin_case();
    @(negedge clk);
    acks_given = 0;
    rst_seen   = 0;
    start_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R1", "busy_o after start", busy_o, 1);
  endtask

  task automatic wait_result(int target, string tag);
    int n = 0;
    while (results < target && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(results >= target, tag, "result arrived", results, target);
    chk(byte_q.size() == 0, tag, "status bytes left over", byte_q.size(), 0);
    byte_q.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(string tag, bit is_fail, int reads);
    int target;
    exp_q.push_back('{is_fail, reads, tag});
    target = results + 1;
    begin_case();
    wait_result(target, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_req_o && !rst_cmd_o && !done_o && !fail_o && !busy_o, "R11",
        "outputs in reset", {rd_req_o, rst_cmd_o, done_o, fail_o, busy_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !rd_req_o, "R11", "idle after reset", {busy_o, rd_req_o}, 0);

    // R2: stable toggle bit
    byte_q = '{8'h00, 8'h00};
    run_case("R2", 0, 2);
    // R3: only bit 5 differs, toggle bit stable
    byte_q = '{8'h44, 8'h64};
    run_case("R3", 0, 2);
    // R4: busy pair then stable pair
    byte_q = '{8'h00, 8'h40, 8'h40, 8'h40};
    run_case("R4", 0, 4);
    // R5: timeout seen, confirm pair stable -> done
    byte_q = '{8'h00, 8'h60, 8'h60, 8'h60};
    run_case("R5", 0, 4);
    // R6: timeout seen, confirm pair still toggles -> reset cmd + fail
    byte_q = '{8'h00, 8'h60, 8'h20, 8'h60};
    run_case("R6", 1, 4);
    // R6: confirm pair toggles with bit 5 clear still fails
    byte_q = '{8'h00, 8'h60, 8'h00, 8'h40};
    run_case("R6", 1, 4);
    // R8: MAX_PAIRS=4 busy pairs -> fail
    byte_q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40};
    run_case("R8", 1, 8);
    // R8: three busy pairs then stable pair -> done
    byte_q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h40, 8'h40};
    run_case("R8", 0, 8);

    // R7: yield after confirm pair's first read; restart clears confirm
    begin
      int target;
      byte_q = '{8'h00, 8'h60, 8'h40};
      stop_after = 3;
      exp_q.push_back('{0, 7, "R7"});
      target = results + 1;
      begin_case();
      repeat (20) @(negedge clk);
      chk(acks_given == 3, "R7", "reads before yield", acks_given, 3);
      yield_i = 1'b1;
      repeat (3) @(negedge clk);
      chk(!rd_req_o, "R7", "no read request while yielding", rd_req_o, 0);
      chk(busy_o, "R7", "busy held while yielding", busy_o, 1);
      chk(results == target - 1, "R7", "no result while yielding", results, target - 1);
      byte_q = '{8'h00, 8'h40, 8'h40, 8'h40};
      stop_after = 1000000;
      yield_i = 1'b0;
      wait_result(target, "R7");
    end

    // R1: start ignored while busy (second start does not add a result)
    begin
      int target;
      byte_q = '{8'h00, 8'h00};
      stop_after = 0;
      exp_q.push_back('{0, 2, "R1"});
      target = results + 1;
      begin_case();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      stop_after = 1000000;
      wait_result(target, "R1");
      repeat (10) @(negedge clk);
      chk(results == target && !busy_o, "R1", "extra start caused activity",
          results, target);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule